// File: doc/BRIEF.md
# Fixed off-time current chopper

This block is the digital control core of a fixed off-time PWM current regulator for one H-bridge winding. While the bridge drives current into the winding, a digitized current-sense comparator reports when the current has reached its target. The block then turns the drive off for a programmed number of clock cycles and resumes drive on its own. During this off period the bridge either recirculates the current slowly (slow decay) or returns it to the supply quickly (fast decay).

After every internally commanded switch into drive, the comparator is ignored for a programmed blanking interval. This keeps switching transients from being taken as a trip. The decay style chosen by the decay select input is used only after the last accepted step strobe announced a lower target current; otherwise the off period uses slow decay. In mixed style each off period opens with fast decay for a programmed count and finishes in slow decay. The off-time, blanking and fast-decay counts are written together through a load strobe.

The bridge outputs are forced to coast by an active-low enable, a fault input, an undervoltage input and an active-low sleep input. Step strobes pass through to an external step translator whatever the enable state. They are held back during undervoltage, during sleep and for a settling count after waking. Undervoltage also sends a one-cycle home pulse to the translator.

Top module: `toff_chopper`

## Requirements
- R1: When `trip_i` is accepted in drive, `bridge_o` leaves drive at the next clock edge. It stays in a decay code (2'b10 or 2'b11) for exactly the loaded off count, with a loaded count of 0 acting as 1, and then returns to drive (2'b01) without further input. `cfg_we_i` high at a clock edge loads the off, blank and fast-decay counts together.
- R2: Each time the control logic enters drive, the drive cycles are numbered from 0. A trip present in any drive cycle numbered below the loaded blank count is discarded and not remembered. A trip in the cycle numbered exactly the blank count, or in any later drive cycle, is accepted.
- R3: `decay_sel_i` encoding: 2'b00 slow, 2'b01 fast, 2'b10 mixed, 2'b11 behaves as slow. The selection is used only if the last step forwarded on `step_fwd_o` had `step_lower_i` = 1. Otherwise the off period is all slow decay (2'b11).
- R4: In mixed style the first min(fast count, off length) cycles of an off period show 2'b10 and the rest show 2'b11. A fast count equal to or above the off length makes the whole period fast. Slow decay is never followed by fast decay within one off period.
- R5: `bridge_o` encoding: 2'b00 coast, 2'b01 drive, 2'b10 fast decay, 2'b11 slow decay. `en_n_i` high forces 2'b00 in the same cycle. `step_fwd_o` follows `step_i` regardless of `en_n_i`.
- R6: `fault_i` high forces 2'b00 in the same cycle. The first cycle after the fault clears is coast, then drive resumes and chopping continues.
- R7: `uvlo_i` high forces 2'b00 and blocks `step_fwd_o`. `home_rst_o` pulses high for exactly one cycle, after the first clock edge at which `uvlo_i` is seen high. The lower-current flag used by R3 is cleared.
- R8: `sleep_n_i` low forces 2'b00 and blocks `step_fwd_o`. After `sleep_n_i` returns high, steps stay blocked for WAKE_CYCLES clock edges and pass from then on.
- R9: A step that arrives during an off period does not change the decay of that period. It takes effect from the next off period.
- R10: While reset is applied, `bridge_o` is 2'b00 and `home_rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trip_i | input | 1 | Digitized current-sense comparator, high when the target current is reached |
| step_i | input | 1 | Step strobe toward the translator |
| step_lower_i | input | 1 | With a step: the new target current is lower than the previous one |
| decay_sel_i | input | 2 | Decay style select (R3 encoding) |
| cfg_we_i | input | 1 | Load strobe for the three counts |
| cfg_off_i | input | CW | Off-time in cycles |
| cfg_blank_i | input | CW | Blanking time in cycles |
| cfg_fd_i | input | CW | Fast-decay portion in cycles for mixed style |
| en_n_i | input | 1 | Active-low output enable |
| fault_i | input | 1 | Over-temperature or low gate-supply fault |
| uvlo_i | input | 1 | Logic supply undervoltage |
| sleep_n_i | input | 1 | Active-low sleep |
| bridge_o | output | 2 | Bridge state code (R5 encoding) |
| step_fwd_o | output | 1 | Step strobe passed to the translator |
| home_rst_o | output | 1 | One-cycle pulse returning the translator to home |

## Verification
The main function is exercised with a table of configurations. Each decay select is run with the lower-current flag set and cleared. The fast count is set below the off length, at zero and above the off length, and the off count at zero. The reserved select code is also used. Together these separate an all-slow period, an all-fast period and a true fast-then-slow split, and they show the off length, including the clamp of zero to one cycle. Directed single-cycle trips one cycle before and exactly at the end of blanking show where a trip starts to count and that an early trip is not held. A step issued during an off period shows that the running period keeps its decay and the next period changes.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    BR_COAST = 2'b00,
    BR_DRIVE = 2'b01,
    BR_FAST  = 2'b10,
    BR_SLOW  = 2'b11
  } bridge_e;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'b00,
    DK_FAST  = 2'b01,
    DK_MIXED = 2'b10,
    DK_RSVD  = 2'b11
  } decay_e;

  typedef enum logic [1:0] {
    ST_COAST = 2'b00,
    ST_DRIVE = 2'b01,
    ST_OFF   = 2'b10
  } chop_st_e;

endpackage

// File: rtl/chop_cfg.sv
module chop_cfg #(
  parameter int unsigned CW        = 16,
  parameter int unsigned DEF_OFF   = 400,
  parameter int unsigned DEF_BLANK = 56,
  parameter int unsigned DEF_FD    = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [CW-1:0] off_i,
  input  logic [CW-1:0] blank_i,
  input  logic [CW-1:0] fd_i,
  output logic [CW-1:0] off_len_o,
  output logic [CW-1:0] blank_o,
  output logic [CW-1:0] fd_o
);

  localparam logic [CW-1:0] RST_OFF   = CW'(DEF_OFF);
  localparam logic [CW-1:0] RST_BLANK = CW'(DEF_BLANK);
  localparam logic [CW-1:0] RST_FD    = CW'(DEF_FD);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW-1:0] off_q, off_d;
  logic [CW-1:0] blank_q, blank_d;
  logic [CW-1:0] fd_q, fd_d;

  always_comb begin
    off_d   = off_q;
    blank_d = blank_q;
    fd_d    = fd_q;
    if (we_i) begin
      off_d   = off_i;
      blank_d = blank_i;
      fd_d    = fd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= RST_OFF;
      blank_q <= RST_BLANK;
      fd_q    <= RST_FD;
    end else begin
      off_q   <= off_d;
      blank_q <= blank_d;
      fd_q    <= fd_d;
    end
  end

  // a zero off-time would never let the period end: treat it as one cycle
  assign off_len_o = (off_q == '0) ? ONE : off_q;
  assign blank_o   = blank_q;
  assign fd_o      = fd_q;

endmodule

// File: rtl/chop_trip_sync.sv
module chop_trip_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES == 0) begin : g_direct
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q, sh_d;

      always_comb begin
        sh_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
          sh_d[i] = sh_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end

      assign q_o = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/chop_wake.sv
module chop_wake #(
  parameter int unsigned WAKE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n_i,
  input  logic uvlo_i,
  input  logic step_i,
  input  logic lower_i,
  output logic step_fwd_o,
  output logic lower_o,
  output logic home_o
);

  localparam int unsigned WW = $clog2(WAKE_CYCLES + 2);
  localparam logic [WW-1:0] WAKE_LD = WW'(WAKE_CYCLES);

  logic [WW-1:0] cnt_q, cnt_d;
  logic          lower_q, lower_d;
  logic          uvlo_q;
  logic          home_q, home_d;
  logic          ready;

  always_comb begin
    cnt_d = cnt_q;
    if (!sleep_n_i)          cnt_d = WAKE_LD;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  assign ready      = sleep_n_i && (cnt_q == '0) && !uvlo_i;
  assign step_fwd_o = step_i && ready;

  always_comb begin
    lower_d = lower_q;
    if (uvlo_i)          lower_d = 1'b0;
    else if (step_fwd_o) lower_d = lower_i;
  end

  assign home_d = uvlo_i && !uvlo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= WAKE_LD;
      lower_q <= 1'b0;
      uvlo_q  <= 1'b0;
      home_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      lower_q <= lower_d;
      uvlo_q  <= uvlo_i;
      home_q  <= home_d;
    end
  end

  assign lower_o = lower_q;
  assign home_o  = home_q;

endmodule

// File: rtl/chop_blank.sv
module chop_blank #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          run_i,
  output logic          open_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                      cnt_d = len_i;
    else if (run_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign open_o = (cnt_q == '0);

endmodule

// File: rtl/chop_offtimer.sv
module chop_offtimer
  import chop_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          run_i,
  input  decay_e        mode_i,
  input  logic [CW-1:0] off_len_i,
  input  logic [CW-1:0] fd_len_i,
  output logic          done_o,
  output logic          fast_o
);

  logic [CW-1:0] el_q, el_d;
  decay_e        mode_q, mode_d;
  logic [CW-1:0] last_el;

  assign last_el = off_len_i - 1'b1;
  // >= keeps the period finite if the length shrinks while it runs
  assign done_o  = (el_q >= last_el);

  always_comb begin
    el_d   = el_q;
    mode_d = mode_q;
    if (start_i) begin
      el_d   = '0;
      mode_d = mode_i;
    end else if (run_i && !done_o) begin
      el_d   = el_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_q   <= '0;
      mode_q <= DK_SLOW;
    end else begin
      el_q   <= el_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    case (mode_q)
      DK_FAST:  fast_o = 1'b1;
      DK_MIXED: fast_o = (el_q < fd_len_i);
      default:  fast_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/toff_chopper.sv
module toff_chopper
  import chop_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned DEF_OFF     = 400,
  parameter int unsigned DEF_BLANK   = 56,
  parameter int unsigned DEF_FD      = 100,
  parameter int unsigned WAKE_CYCLES = 50000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_i,
  input  logic          step_i,
  input  logic          step_lower_i,
  input  logic [1:0]    decay_sel_i,
  input  logic          cfg_we_i,
  input  logic [CW-1:0] cfg_off_i,
  input  logic [CW-1:0] cfg_blank_i,
  input  logic [CW-1:0] cfg_fd_i,
  input  logic          en_n_i,
  input  logic          fault_i,
  input  logic          uvlo_i,
  input  logic          sleep_n_i,
  output logic [1:0]    bridge_o,
  output logic          step_fwd_o,
  output logic          home_rst_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [CW-1:0] cfg_off_w, cfg_blank_w, cfg_fd_w;
  logic          trip_s;
  logic          lower_q;
  logic          blank_open, blank_load;
  logic          off_done, off_fast, off_start;
  logic          gate;
  chop_st_e      st_q, st_d;
  decay_e        sel_mode;
  bridge_e       bridge;

  chop_cfg #(
    .CW(CW), .DEF_OFF(DEF_OFF), .DEF_BLANK(DEF_BLANK), .DEF_FD(DEF_FD)
  ) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .we_i(cfg_we_i),
    .off_i(cfg_off_i), .blank_i(cfg_blank_i), .fd_i(cfg_fd_i),
    .off_len_o(cfg_off_w), .blank_o(cfg_blank_w), .fd_o(cfg_fd_w)
  );

  chop_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(trip_i), .q_o(trip_s)
  );

  chop_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst_n(rst_int_n), .sleep_n_i(sleep_n_i), .uvlo_i(uvlo_i),
    .step_i(step_i), .lower_i(step_lower_i), .step_fwd_o(step_fwd_o),
    .lower_o(lower_q), .home_o(home_rst_o)
  );

  assign gate = en_n_i || fault_i || uvlo_i || !sleep_n_i;

  // next-state
  always_comb begin
    st_d = st_q;
    if (gate) begin
      st_d = ST_COAST;
    end else begin
      case (st_q)
        ST_COAST: st_d = ST_DRIVE;
        ST_DRIVE: if (blank_open && trip_s) st_d = ST_OFF;
        ST_OFF:   if (off_done) st_d = ST_DRIVE;
        default:  st_d = ST_COAST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ST_COAST;
    else            st_q <= st_d;
  end

  assign blank_load = (st_q != ST_DRIVE) && (st_d == ST_DRIVE);
  assign off_start  = (st_q == ST_DRIVE) && (st_d == ST_OFF);
  assign sel_mode   = lower_q ? decay_e'(decay_sel_i) : DK_SLOW;

  chop_blank #(.CW(CW)) u_blank (
    .clk(clk), .rst_n(rst_int_n), .load_i(blank_load), .len_i(cfg_blank_w),
    .run_i(st_q == ST_DRIVE), .open_o(blank_open)
  );

  chop_offtimer #(.CW(CW)) u_off (
    .clk(clk), .rst_n(rst_int_n), .start_i(off_start), .run_i(st_q == ST_OFF),
    .mode_i(sel_mode), .off_len_i(cfg_off_w), .fd_len_i(cfg_fd_w),
    .done_o(off_done), .fast_o(off_fast)
  );

  // output decode; protection inputs mask it in the same cycle
  always_comb begin
    bridge = BR_COAST;
    if (!gate) begin
      case (st_q)
        ST_DRIVE: bridge = BR_DRIVE;
        ST_OFF:   bridge = off_fast ? BR_FAST : BR_SLOW;
        default:  bridge = BR_COAST;
      endcase
    end
  end

  assign bridge_o = bridge;

endmodule

// File: rtl/chop_chk.sv
module chop_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_n,
  input logic          fault,
  input logic          uvlo,
  input logic          sleep_n,
  input logic          step_in,
  input logic          step_fwd,
  input logic          home,
  input logic [1:0]    bridge,
  input logic [CW-1:0] blank_len,
  input logic [CW-1:0] off_len
);

  localparam int unsigned RW = CW + 2;
  localparam logic [RW-1:0] RMAX = '1;

  logic          gate;
  logic [RW-1:0] drv_run, off_run;

  assign gate = en_n || fault || uvlo || !sleep_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_run <= '0;
      off_run <= '0;
    end else begin
      if (bridge == 2'b01) drv_run <= (drv_run == RMAX) ? RMAX : drv_run + 1'b1;
      else                 drv_run <= '0;
      if (bridge[1])       off_run <= (off_run == RMAX) ? RMAX : off_run + 1'b1;
      else                 off_run <= '0;
    end
  end

  AST_OFF_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && $past(!gate) && $past(bridge[1]) && bridge == 2'b01)
      |-> (off_run == RW'(off_len)));  // R1

  AST_DRIVE_MIN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && $past(!gate) && $past(bridge) == 2'b01 && bridge[1])
      |-> (drv_run >= RW'(blank_len) + 1'b1));  // R2

  AST_FAST_BEFORE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && $past(!gate) && $past(bridge) == 2'b11) |-> (bridge != 2'b10));  // R4

  AST_STEP_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    step_fwd |-> step_in);  // R5

  AST_HOME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    home |=> !home);  // R7

  AST_HOME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(home) |-> $past(uvlo));  // R7

  AST_ASLEEP_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !step_fwd);  // R8

endmodule

bind toff_chopper chop_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n_i), .fault(fault_i), .uvlo(uvlo_i),
  .sleep_n(sleep_n_i), .step_in(step_i), .step_fwd(step_fwd_o),
  .home(home_rst_o), .bridge(bridge_o), .blank_len(cfg_blank_w),
  .off_len(cfg_off_w)
);

// File: tb/test_toff_chopper.sv
module test_toff_chopper;

  localparam int CW = 8;
  localparam int WAKE = 40;
  localparam int NV = 8;

  // vectors: decay select, lower flag, off, blank, fast count -> fast cycles, off length
  localparam int V_SEL [NV] = '{0, 1, 2, 2, 1, 2, 3, 2};
  localparam int V_LOW [NV] = '{1, 1, 1, 1, 0, 1, 1, 1};
  localparam int V_OFF [NV] = '{10, 8, 12, 6, 7, 0, 5, 9};
  localparam int V_BLK [NV] = '{3, 2, 4, 1, 0, 2, 1, 2};
  localparam int V_FD  [NV] = '{4, 3, 5, 9, 2, 0, 3, 0};
  localparam int V_NF  [NV] = '{0, 8, 5, 6, 0, 0, 0, 0};
  localparam int V_LEN [NV] = '{10, 8, 12, 6, 7, 1, 5, 9};

  logic clk = 1'b0;
  logic rst_n, trip, step, lower, cfg_we, en_n, fault, uvlo, sleep_n;
  logic [1:0] sel;
  logic [CW-1:0] c_off, c_blk, c_fd;
  logic [1:0] bridge;
  logic step_fwd, home;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  toff_chopper #(
    .CW(CW), .DEF_OFF(10), .DEF_BLANK(3), .DEF_FD(4),
    .WAKE_CYCLES(WAKE), .SYNC_STAGES(0)
  ) i_toff_chopper (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .step_i(step),
    .step_lower_i(lower), .decay_sel_i(sel), .cfg_we_i(cfg_we),
    .cfg_off_i(c_off), .cfg_blank_i(c_blk), .cfg_fd_i(c_fd),
    .en_n_i(en_n), .fault_i(fault), .uvlo_i(uvlo), .sleep_n_i(sleep_n),
    .bridge_o(bridge), .step_fwd_o(step_fwd), .home_rst_o(home)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int o, input int b, input int f);
    @(negedge clk);
    c_off = CW'(o); c_blk = CW'(b); c_fd = CW'(f); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_step(input logic lw);
    @(negedge clk);
    step = 1'b1; lower = lw;
    @(negedge clk);
    step = 1'b0;
  endtask

  // trip for one cycle; returns in the first off cycle
  task automatic pulse_trip();
    @(negedge clk);
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trip = 1'b0; step = 1'b0; lower = 1'b0; cfg_we = 1'b0;
    en_n = 1'b0; fault = 1'b0; uvlo = 1'b0; sleep_n = 1'b1; sel = 2'b00;
    c_off = '0; c_blk = '0; c_fd = '0;

    repeat (3) @(negedge clk);
    chk("R10 bridge in reset", bridge, 0);
    chk("R10 home in reset", home, 0);
    rst_n = 1'b1;
    repeat (WAKE + 20) @(negedge clk);
    chk("R1 drive after reset", bridge, 1);

    // table walk: decay styles and off lengths (R1 R3 R4)
    for (int i = 0; i < NV; i++) begin
      sel = 2'(V_SEL[i]);
      load_cfg(V_OFF[i], V_BLK[i], V_FD[i]);
      do_step(V_LOW[i][0]);
      repeat (40) @(negedge clk);
      pulse_trip();
      for (int j = 0; j < V_LEN[i]; j++) begin
        chk($sformatf("R3/R4 vec %0d off cycle %0d", i, j), bridge,
            (j < V_NF[i]) ? 2 : 3);
        @(negedge clk);
      end
      chk($sformatf("R1 vec %0d resume drive", i), bridge, 1);
    end

    // R2: blanking edges
    sel = 2'b00;
    load_cfg(4, 3, 0);
    repeat (20) @(negedge clk);
    pulse_trip();
    repeat (4) @(negedge clk);
    chk("R2 drive cycle 0", bridge, 1);
    repeat (2) @(negedge clk);
    trip = 1'b1;                // drive cycle 2 = blank-1
    @(negedge clk);
    trip = 1'b0;
    chk("R2 early trip discarded", bridge, 1);
    repeat (3) @(negedge clk);
    chk("R2 early trip not latched", bridge, 1);
    pulse_trip();
    repeat (4) @(negedge clk);
    repeat (3) @(negedge clk);
    trip = 1'b1;                // drive cycle 3 = blank
    @(negedge clk);
    trip = 1'b0;
    chk("R2 trip at blank end accepted", bridge, 3);
    repeat (20) @(negedge clk);

    // R5: enable
    en_n = 1'b1;
    #1 chk("R5 enable off coasts", bridge, 0);
    step = 1'b1; lower = 1'b0;
    #1 chk("R5 step passes while disabled", step_fwd, 1);
    @(negedge clk);
    step = 1'b0;
    en_n = 1'b0;
    #1 chk("R5 coast cycle after enable", bridge, 0);
    @(negedge clk);
    chk("R5 drive after enable", bridge, 1);

    // R6: fault during off
    load_cfg(10, 1, 0);
    repeat (10) @(negedge clk);
    pulse_trip();
    fault = 1'b1;
    #1 chk("R6 fault coasts", bridge, 0);
    repeat (3) @(negedge clk);
    chk("R6 fault holds coast", bridge, 0);
    fault = 1'b0;
    #1 chk("R6 first cycle after fault", bridge, 0);
    @(negedge clk);
    chk("R6 drive resumes", bridge, 1);
    repeat (5) @(negedge clk);
    pulse_trip();
    chk("R6 chopping resumes", bridge, 3);
    repeat (20) @(negedge clk);

    // R9: step during off period
    sel = 2'b01;
    do_step(1'b0);
    repeat (5) @(negedge clk);
    pulse_trip();
    chk("R9 slow before step", bridge, 3);
    repeat (2) @(negedge clk);
    step = 1'b1; lower = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk("R9 running period unchanged", bridge, 3);
    repeat (7) @(negedge clk);
    chk("R9 period ends on time", bridge, 1);
    repeat (10) @(negedge clk);
    pulse_trip();
    chk("R9 next period uses fast", bridge, 2);
    repeat (20) @(negedge clk);

    // R7: undervoltage
    uvlo = 1'b1;
    #1 chk("R7 uvlo coasts", bridge, 0);
    step = 1'b1; lower = 1'b1;
    #1 chk("R7 step blocked", step_fwd, 0);
    @(negedge clk);
    chk("R7 home pulse", home, 1);
    @(negedge clk);
    chk("R7 home pulse one cycle", home, 0);
    step = 1'b0;
    uvlo = 1'b0;
    repeat (20) @(negedge clk);
    pulse_trip();
    chk("R7 falling flag cleared", bridge, 3);
    repeat (20) @(negedge clk);

    // R8: sleep and wake settling
    sleep_n = 1'b0;
    step = 1'b1;
    #1 chk("R8 sleep coasts", bridge, 0);
    chk("R8 step blocked asleep", step_fwd, 0);
    repeat (3) @(negedge clk);
    sleep_n = 1'b1;
    repeat (WAKE - 1) @(negedge clk);
    chk("R8 step blocked while settling", step_fwd, 0);
    @(negedge clk);
    chk("R8 step passes after settling", step_fwd, 1);
    step = 1'b0;
    repeat (5) @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule